// File: doc/BRIEF.md
# SPI Mode-1 Peripheral Frame Interface

This block is the serial front end of a converter-style peripheral. An external controller selects it with an active-low chip select and clocks it in SPI mode 1: the serial clock idles low, the peripheral launches each outgoing bit on a rising clock edge, and both sides capture on a falling edge. Command words arrive on the serial data input while a response or data word leaves on the serial data output in the same frame, so the link is full duplex. All three bus inputs are oversampled by a faster system clock. The system clock has to run at least four times the serial clock rate.

Inside the system-clock domain, the block passes each received word to downstream logic with a one-cycle strobe. It samples the next transmit word from a parallel load port at that same moment. It also reports how many words the current frame has completed, so that readout logic can track which words the controller has collected. The output driver is enabled only while the peripheral is selected. When chip select goes high, the block drops whatever part of the frame was in progress and is ready for a clean new frame.

Top module: `spi_m1_target`

## Requirements
- R1: While the synchronised chip select is high, `miso_oe` is 0, `miso_out` is 0 and `word_count` is 0. These hold from reset and return within 4 system clocks after chip select rises.
- R2: When chip select falls, `miso_oe` goes to 1 and `miso_out` shows bit W-1 of `tx_word` before the first serial clock rising edge.
- R3: Each serial clock rising edge after the first one of a word moves `miso_out` to the next lower bit of the transmit word. Bits go out MSB first, and each bit stays stable until the next rising edge.
- R4: The serial data input is captured on each serial clock falling edge, MSB first. After W falling edges, `rx_word` holds the W captured bits, with the first bit in position W-1.
- R5: `rx_valid` is a single-cycle pulse. It occurs once for each completed word, in the cycle where `rx_word` takes the new value.
- R6: `tx_word` is sampled when a word completes. Its bit W-1 is on `miso_out` before the next rising edge, so the words of a frame follow each other with no gap bits.
- R7: Taking chip select high during a word discards it: no `rx_valid` is produced. The next frame starts again at bit W-1 for both directions.
- R8: `word_count` rises by one at each completed word of the current frame and clears to 0 when chip select goes high. It stops at its all-ones value.
- R9: Serial clock and data activity while chip select is high has no effect. It produces no `rx_valid` and leaves no bits in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the controller (asynchronous) |
| csn_in | input | 1 | Active-low chip select (asynchronous) |
| mosi_in | input | 1 | Serial data from the controller (asynchronous) |
| miso_out | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | Output enable for `miso_out`; 0 models high impedance |
| tx_word | input | W | Next word to transmit, sampled at frame start and at each word end |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |
| rx_word | output | W | Most recently completed received word |
| word_count | output | CNT_W | Words completed in the current frame |

## Verification
The checker watches several properties on every cycle. The output enable and the strobe must fall silent one cycle after the synchronised chip select is seen high. The strobe must never last longer than one cycle, and it must always follow a detected falling edge. The word counter may only step up by one or clear. `miso_out` may change only on a rising edge, a word load or frame start. Other behaviour only the directed scenarios can show: the actual bit order in both directions, the value of each received word, the hand-over from one transmit word to the next in a burst, and the clean restart after an aborted frame or after clocking while deselected.

// File: rtl/spi_m1_pkg.sv
package spi_m1_pkg;

  // Synchronised bus pins, grouped so they share one synchroniser
  typedef struct packed {
    logic sclk;
    logic csn;
    logic mosi;
  } bus_pins_t;

  // Bit index after a falling edge: wraps to zero after the last bit
  function automatic int unsigned bit_next(input int unsigned cur, input int unsigned width);
    return (cur == width - 1) ? 0 : cur + 1;
  endfunction

  // True when the falling edge at index cur closes a word
  function automatic bit is_last_bit(input int unsigned cur, input int unsigned width);
    return cur == width - 1;
  endfunction

  // Saturating increment for the per-frame word counter
  function automatic int unsigned count_next(input int unsigned cur, input int unsigned maxv);
    return (cur >= maxv) ? maxv : cur + 1;
  endfunction

endpackage

// File: rtl/spi_m1_sync.sv
module spi_m1_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {2{RST_VAL[i]}};
      else        stage <= {stage[0], d[i]};
    end
    assign q[i] = stage[1];
  end

endmodule

// File: rtl/spi_m1_edge.sv
module spi_m1_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic csn_s,
  output logic sel,
  output logic cs_fall,
  output logic rise_evt,
  output logic fall_evt
);

  logic sclk_d;
  logic csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign sel      = ~csn_s;
  assign cs_fall  = csn_d & ~csn_s;
  assign rise_evt = sel &  sclk_s & ~sclk_d;
  assign fall_evt = sel & ~sclk_s &  sclk_d;

endmodule

// File: rtl/spi_m1_shift.sv
module spi_m1_shift #(
  parameter int W     = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             cs_fall,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             mosi_s,
  input  logic [W-1:0]     tx_word,
  output logic             miso_out,
  output logic             miso_oe,
  output logic             rx_valid,
  output logic [W-1:0]     rx_word,
  output logic [CNT_W-1:0] word_count,
  output logic             word_done,
  output logic             load_evt
);
  import spi_m1_pkg::*;

  localparam int BW = (W > 2) ? $clog2(W) : 1;
  localparam int unsigned CNT_MAX = (2 ** CNT_W) - 1;

  logic [BW-1:0] bit_cnt;
  logic [W-1:0]  rx_sh;
  logic [W-1:0]  tx_sh;
  logic          oe_q;
  logic [W-1:0]  rx_next;

  assign rx_next   = {rx_sh[W-2:0], mosi_s};
  assign word_done = fall_evt && is_last_bit(int'(bit_cnt), W);
  assign load_evt  = cs_fall | word_done;

  // Receive side and bit counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      rx_valid   <= 1'b0;
      word_count <= '0;
    end else if (!sel) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      rx_valid   <= 1'b0;
      word_count <= '0;
    end else begin
      rx_valid <= word_done;
      if (fall_evt) begin
        rx_sh   <= rx_next;
        bit_cnt <= BW'(bit_next(int'(bit_cnt), W));
      end
      if (word_done)
        word_count <= CNT_W'(count_next(int'(word_count), CNT_MAX));
    end
  end

  // Received word is held across frames until the next completed word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_word <= '0;
    else if (word_done) rx_word <= rx_next;
  end

  // Transmit side: load at frame start and word end, shift on later rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      oe_q  <= 1'b0;
    end else if (!sel) begin
      tx_sh <= '0;
      oe_q  <= 1'b0;
    end else begin
      if (cs_fall) oe_q <= 1'b1;
      if (load_evt)
        tx_sh <= tx_word;
      else if (rise_evt && bit_cnt != '0)
        tx_sh <= {tx_sh[W-2:0], 1'b0};
    end
  end

  assign miso_oe  = oe_q;
  assign miso_out = oe_q & tx_sh[W-1];

endmodule

// File: rtl/spi_m1_target.sv
module spi_m1_target #(
  parameter int W     = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic             csn_in,
  input  logic             mosi_in,
  output logic             miso_out,
  output logic             miso_oe,
  input  logic [W-1:0]     tx_word,
  output logic             rx_valid,
  output logic [W-1:0]     rx_word,
  output logic [CNT_W-1:0] word_count
);
  import spi_m1_pkg::*;

  bus_pins_t pins_raw;
  bus_pins_t pins_s;

  // Named internal events, brought out for the checker
  logic sel;
  logic cs_fall;
  logic rise_evt;
  logic fall_evt;
  logic word_done;
  logic load_evt;

  assign pins_raw = '{sclk: sclk_in, csn: csn_in, mosi: mosi_in};

  spi_m1_sync #(
    .N       ($bits(bus_pins_t)),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  spi_m1_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s.sclk),
    .csn_s    (pins_s.csn),
    .sel      (sel),
    .cs_fall  (cs_fall),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  spi_m1_shift #(
    .W     (W),
    .CNT_W (CNT_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .cs_fall    (cs_fall),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .mosi_s     (pins_s.mosi),
    .tx_word    (tx_word),
    .miso_out   (miso_out),
    .miso_oe    (miso_oe),
    .rx_valid   (rx_valid),
    .rx_word    (rx_word),
    .word_count (word_count),
    .word_done  (word_done),
    .load_evt   (load_evt)
  );

endmodule

// File: rtl/spi_m1_target_sva.sv
module spi_m1_target_sva #(
  parameter int W     = 24,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             load_evt,
  input logic             miso_out,
  input logic             miso_oe,
  input logic             rx_valid,
  input logic [CNT_W-1:0] word_count
);

  assert_oe_off_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso_oe);

  assert_no_strobe_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !rx_valid);

  assert_dout_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !rise_evt && !load_evt) |=> $stable(miso_out));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_strobe_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(fall_evt));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_count) |-> (word_count == '0 ||
                              word_count == CNT_W'($past(word_count) + 1'b1)));

  assert_count_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> word_count != '0);

endmodule

bind spi_m1_target spi_m1_target_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt),
  .load_evt   (load_evt),
  .miso_out   (miso_out),
  .miso_oe    (miso_oe),
  .rx_valid   (rx_valid),
  .word_count (word_count)
);

// File: tb/spi_m1_target_test.sv
module spi_m1_target_test;
  localparam int W     = 24;
  localparam int CNT_W = 8;
  localparam int HALF  = 4;   // system clocks per serial half period

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sclk_in = 1'b0;
  logic             csn_in = 1'b1;
  logic             mosi_in = 1'b0;
  logic             miso_out;
  logic             miso_oe;
  logic [W-1:0]     tx_word = '0;
  logic             rx_valid;
  logic [W-1:0]     rx_word;
  logic [CNT_W-1:0] word_count;

  int n_tests = 0;
  int n_fail  = 0;
  int n_got   = 0;
  bit finished = 0;
  logic [W-1:0] got_q [8];
  logic [W-1:0] tx_q [4];
  logic [W-1:0] rx_q [4];

  always #4 clk = ~clk;  // 125 MHz

  spi_m1_target #(.W(W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .csn_in(csn_in),
    .mosi_in(mosi_in), .miso_out(miso_out), .miso_oe(miso_oe),
    .tx_word(tx_word), .rx_valid(rx_valid), .rx_word(rx_word),
    .word_count(word_count)
  );

  // Capture every strobed word away from the active edge
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (n_got < 8) got_q[n_got] = rx_word;
      n_got = n_got + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One word: controller launches on rising, device bit checked before falling
  task automatic send_word(input logic [W-1:0] din, input logic [W-1:0] exp_dout,
                           input logic [W-1:0] next_tx);
    for (int i = W - 1; i >= 0; i--) begin
      mosi_in = din[i];
      sclk_in = 1'b1;
      tick(HALF);
      check_eq("R3", "dout bit", {31'd0, miso_out}, {31'd0, exp_dout[i]});
      if (i == W - 1) tx_word = next_tx;
      sclk_in = 1'b0;
      tick(HALF);
    end
  endtask

  task automatic frame(input int nw);
    int base;
    base = n_got;
    tx_word = tx_q[0];
    csn_in = 1'b0;
    tick(HALF);
    check_eq("R2", "oe at select", {31'd0, miso_oe}, 32'd1);
    check_eq("R2", "first bit", {31'd0, miso_out}, {31'd0, tx_q[0][W-1]});
    for (int k = 0; k < nw; k++) begin
      send_word(rx_q[k], tx_q[k], (k + 1 < nw) ? tx_q[k+1] : '0);
      check_eq("R6", "dout msb of next word", {31'd0, miso_out},
               {31'd0, (k + 1 < nw) ? tx_q[k+1][W-1] : 1'b0});
    end
    check_eq("R5", "strobe count", n_got - base, nw);
    for (int k = 0; k < nw; k++)
      check_eq("R4", "received word", {8'd0, got_q[base+k]}, {8'd0, rx_q[k]});
    check_eq("R8", "word count", {24'd0, word_count}, nw);
    csn_in = 1'b1;
    tick(HALF);
    check_eq("R1", "oe after deselect", {31'd0, miso_oe}, 32'd0);
    check_eq("R8", "count cleared", {24'd0, word_count}, 32'd0);
    tick(HALF);
  endtask

  task automatic t_reset;
    check_eq("R1", "reset oe", {31'd0, miso_oe}, 32'd0);
    check_eq("R1", "reset dout", {31'd0, miso_out}, 32'd0);
    check_eq("R5", "reset strobe", {31'd0, rx_valid}, 32'd0);
    check_eq("R8", "reset count", {24'd0, word_count}, 32'd0);
  endtask

  task automatic t_single;
    tx_q[0] = 24'hA5C30F;
    rx_q[0] = 24'h3C96E1;
    frame(1);
  endtask

  task automatic t_burst;
    tx_q[0] = 24'h800001; rx_q[0] = 24'h123456;
    tx_q[1] = 24'h7FFFFE; rx_q[1] = 24'hFEDCBA;
    tx_q[2] = 24'h5A5A5A; rx_q[2] = 24'h000001;
    frame(3);
  endtask

  task automatic t_abort;
    int base;
    base = n_got;
    tx_word = 24'hFFFFFF;
    csn_in = 1'b0;
    tick(HALF);
    for (int i = 0; i < 7; i++) begin
      mosi_in = 1'b1;
      sclk_in = 1'b1; tick(HALF);
      sclk_in = 1'b0; tick(HALF);
    end
    csn_in = 1'b1;
    tick(2 * HALF);
    check_eq("R7", "no strobe for partial word", n_got - base, 32'd0);
    check_eq("R7", "oe after abort", {31'd0, miso_oe}, 32'd0);
    tx_q[0] = 24'h00F00F;
    rx_q[0] = 24'h0F0F0F;
    frame(1);
    check_eq("R7", "fresh word after abort", {8'd0, got_q[base]}, {8'd0, rx_q[0]});
  endtask

  task automatic t_ignore;
    int base;
    base = n_got;
    for (int i = 0; i < 30; i++) begin
      mosi_in = i[0];
      sclk_in = 1'b1; tick(HALF);
      sclk_in = 1'b0; tick(HALF);
    end
    check_eq("R9", "no strobe while deselected", n_got - base, 32'd0);
    check_eq("R9", "oe while deselected", {31'd0, miso_oe}, 32'd0);
    check_eq("R9", "count while deselected", {24'd0, word_count}, 32'd0);
    tx_q[0] = 24'hC0FFEE;
    rx_q[0] = 24'h9ABCDE;
    frame(1);
    check_eq("R9", "clean word after idle clocks", {8'd0, got_q[base]}, {8'd0, rx_q[0]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    tick(3);
    t_reset;
    rst_n = 1'b1;
    tick(4);
    t_reset;
    t_single;
    t_burst;
    t_abort;
    t_ignore;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule